// File: doc/BRIEF.md
# Shared-Buffer Multi-Queue Manager

This block keeps 64 independent word-wide FIFO queues. All of them live in one single-port buffer RAM inside the block. A host reaches them through a one-request-at-a-time command port. Each request carries a 3-bit opcode, a queue number and a 32-bit data word.

The host places each queue in the buffer with a configuration word. That word sets the queue's base address, its capacity (16, 32, 64 or 128 words) and two watermarks. After that the host can push words, pop words, read a packed status word, or clear the sticky error bits.

For every queue the block holds a read pointer, a write pointer and a fill count. The pointers wrap modulo the capacity, and the physical RAM address is the base plus the pointer. From the count the block derives four registered status flags: empty, nearly empty, nearly full and full. For queues 0 to 31 it also keeps sticky underflow and overflow bits. The four flags of queues 0 to 31 are driven continuously on a 128-bit flag bus, so that neighbouring engines can poll queue state without using the command port.

Top module: `shared_queue_mgr`

## Requirements
- R1: After synchronous reset, every queue has capacity 16, base 0, both watermarks 0, pointers 0 and count 0. Its flags read empty=1, nearly-empty=1, nearly-full=0, full=0. No sticky bit is set, and busy and rsp_valid are low.
- R2: Opcode 0 (push) stores req_wdata in the selected queue, and opcode 1 (pop) returns the oldest stored word on rsp_data. Each queue keeps its own first-in first-out order, whatever accesses to other queues are interleaved.
- R3: Opcode 2 (configure) takes its fields from req_wdata: base address in bits [10:0], size code in bits [13:12] (0=16, 1=32, 2=64, 3=128 words), nearly-empty watermark in bits [23:16] and nearly-full watermark in bits [31:24]. It also resets that queue's pointers and count to zero.
- R4: The read and write pointers wrap modulo the configured capacity. Data stays in order across any number of wraps, starting from any fill level.
- R5: The empty flag is set exactly when the count is 0. The full flag is set exactly when the count equals the capacity.
- R6: Nearly empty is set when count <= nearly-empty watermark. Nearly full is set when (capacity - count) <= nearly-full watermark.
- R7: A push to a full queue is dropped and leaves pointers and count unchanged. A pop from an empty queue returns 0 and leaves them unchanged. For queues 0 to 31 these events set overflow and underflow respectively.
- R8: Underflow and overflow stay set until opcode 4 (clear) is issued with req_wdata bit 0 = 1 (clears underflow) or bit 1 = 1 (clears overflow). A 0 bit leaves its flag unchanged.
- R9: Queues 32 to 63 have no sticky bits: their status word always reads 0 in bits 5 and 4.
- R10: flag_bus[4q+3:4q] carries queue q's flags for q = 0..31, ordered {full, nearly-full, nearly-empty, empty} from bit 3 down to bit 0.
- R11: A request is accepted when req_valid is high and busy is low. A push or pop holds busy high for the two cycles after acceptance. A pop's rsp_valid and rsp_data appear in the cycle after busy falls. The flags change one cycle later than that.
- R12: Opcode 3 (status) returns rsp_valid in the cycle after acceptance, with rsp_data = {count[7:0] in [31:24], read pointer in [22:16], write pointer in [14:8], overflow in [5], underflow in [4], flags in [3:0]}, all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Opcode: 0 push, 1 pop, 2 configure, 3 status, 4 clear sticky |
| req_qid | input | 6 | Queue number |
| req_wdata | input | 32 | Push data, configuration word or clear mask |
| busy | output | 1 | High while a push or pop RAM access is in flight |
| rsp_valid | output | 1 | One-cycle strobe for pop or status data |
| rsp_data | output | 32 | Popped word or status word |
| flag_bus | output | 128 | Four status flags for each of queues 0 to 31 |

## Verification
The bench tries the queues under four stimulus patterns.

- Interleaved pushes and pops across several queues of different sizes separate per-queue ordering from any crosstalk in the shared RAM addressing.
- Filling one queue to capacity and draining it past empty separates correct dropping and sticky capture from a design that advances the pointers anyway.
- Long alternating push/pop runs on a 64-word queue start from a nonzero fill level and wrap many times, which exposes masking errors in pointer wrap.
- Reconfiguring a non-empty queue, and exercising a high-numbered queue, tells the state-reset and the no-sticky-bit behaviour apart from the low-queue path.

// File: rtl/sqm_pkg.sv
package sqm_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CFG  = 3'd2,
    OP_STAT = 3'd3,
    OP_CLR  = 3'd4
  } sqm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC1 = 2'd1,
    ST_ACC2 = 2'd2
  } sqm_st_e;

  // flag nibble bit positions
  localparam int FL_EMPTY = 0;
  localparam int FL_NE    = 1;
  localparam int FL_NF    = 2;
  localparam int FL_FULL  = 3;

endpackage

// File: rtl/sqm_buffer_ram.sv
module sqm_buffer_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, registered output
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/sqm_flag_eval.sv
module sqm_flag_eval #(
  parameter int CNT_W     = 8,
  parameter int MIN_WORDS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       size_code,
  input  logic [CNT_W-1:0] ne_wm,
  input  logic [CNT_W-1:0] nf_wm,
  output logic [3:0]       flags
);
  import sqm_pkg::*;

  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] room;
  logic [3:0]       flags_d;

  always_comb begin
    cap              = CNT_W'(MIN_WORDS) << size_code;
    room             = cap - cnt;
    flags_d          = '0;
    flags_d[FL_EMPTY] = (cnt == '0);
    flags_d[FL_NE]    = (cnt <= ne_wm);
    flags_d[FL_NF]    = (room <= nf_wm);
    flags_d[FL_FULL]  = (cnt == cap);
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= 4'b0011;
    else     flags <= flags_d;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= cap);
endmodule

// File: rtl/shared_queue_mgr.sv
module shared_queue_mgr #(
  parameter int NUM_Q     = 64,
  parameter int LOW_Q     = 32,
  parameter int DATA_W    = 32,
  parameter int RAM_AW    = 11,
  parameter int MIN_WORDS = 16,
  parameter int MAX_WORDS = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [2:0]               req_op,
  input  logic [$clog2(NUM_Q)-1:0] req_qid,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     busy,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic [4*LOW_Q-1:0]       flag_bus
);
  import sqm_pkg::*;

  localparam int QID_W   = $clog2(NUM_Q);
  localparam int PTR_W   = $clog2(MAX_WORDS);
  localparam int CNT_W   = PTR_W + 1;
  localparam int SZ_LSB  = 12;
  localparam int NE_LSB  = 16;
  localparam int NF_LSB  = 24;
  localparam int ST_CNT  = 24;
  localparam int ST_RD   = 16;
  localparam int ST_WR   = 8;
  localparam int ST_UNF  = 4;
  localparam int ST_OVF  = 5;

  // per-queue context
  logic [RAM_AW-1:0] base_r [NUM_Q];
  logic [1:0]        szc_r  [NUM_Q];
  logic [CNT_W-1:0]  ne_r   [NUM_Q];
  logic [CNT_W-1:0]  nf_r   [NUM_Q];
  logic [PTR_W-1:0]  rd_r   [NUM_Q];
  logic [PTR_W-1:0]  wr_r   [NUM_Q];
  logic [CNT_W-1:0]  cnt_r  [NUM_Q];
  logic [3:0]        flg    [NUM_Q];
  logic [LOW_Q-1:0]  unf_r, ovf_r;
  logic [NUM_Q-1:0]  unf_all, ovf_all;

  // access pipeline
  sqm_st_e           state_q;
  sqm_op_e           op_q;
  sqm_op_e           req_op_e;
  logic [QID_W-1:0]  qid_q;
  logic [RAM_AW-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              drop_q;
  logic [DATA_W-1:0] ram_q;
  logic              ram_we;
  logic              accept;
  logic [DATA_W-1:0] stat_word;

  function automatic logic [CNT_W-1:0] cap_of(input logic [1:0] code);
    return CNT_W'(MIN_WORDS) << code;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p, input logic [1:0] code);
    logic [CNT_W-1:0] mask;
    mask = cap_of(code) - 1'b1;
    return (p + 1'b1) & mask[PTR_W-1:0];
  endfunction

  assign req_op_e = sqm_op_e'(req_op);
  assign accept   = req_valid && (state_q == ST_IDLE);
  assign busy     = (state_q != ST_IDLE);
  assign ram_we   = (state_q == ST_ACC1) && (op_q == OP_PUSH) && !drop_q;
  assign unf_all  = NUM_Q'(unf_r);
  assign ovf_all  = NUM_Q'(ovf_r);

  always_comb begin
    stat_word                      = '0;
    stat_word[ST_CNT +: CNT_W]     = cnt_r[req_qid];
    stat_word[ST_RD  +: PTR_W]     = rd_r[req_qid];
    stat_word[ST_WR  +: PTR_W]     = wr_r[req_qid];
    stat_word[ST_OVF]              = ovf_all[req_qid];
    stat_word[ST_UNF]              = unf_all[req_qid];
    stat_word[3:0]                 = flg[req_qid];
  end

  sqm_buffer_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (addr_q),
    .wdata (wdata_q),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_PUSH;
      qid_q     <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      drop_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      for (int q = 0; q < NUM_Q; q++) begin
        base_r[q] <= '0;
        szc_r[q]  <= '0;
        ne_r[q]   <= '0;
        nf_r[q]   <= '0;
        rd_r[q]   <= '0;
        wr_r[q]   <= '0;
        cnt_r[q]  <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          op_q    <= req_op_e;
          qid_q   <= req_qid;
          wdata_q <= req_wdata;
          case (req_op_e)
            OP_PUSH: begin
              addr_q  <= base_r[req_qid] + RAM_AW'(wr_r[req_qid]);
              drop_q  <= (cnt_r[req_qid] == cap_of(szc_r[req_qid]));
              state_q <= ST_ACC1;
            end
            OP_POP: begin
              addr_q  <= base_r[req_qid] + RAM_AW'(rd_r[req_qid]);
              drop_q  <= (cnt_r[req_qid] == '0);
              state_q <= ST_ACC1;
            end
            OP_CFG: begin
              base_r[req_qid] <= req_wdata[RAM_AW-1:0];
              szc_r[req_qid]  <= req_wdata[SZ_LSB +: 2];
              ne_r[req_qid]   <= req_wdata[NE_LSB +: CNT_W];
              nf_r[req_qid]   <= req_wdata[NF_LSB +: CNT_W];
              rd_r[req_qid]   <= '0;
              wr_r[req_qid]   <= '0;
              cnt_r[req_qid]  <= '0;
            end
            OP_STAT: begin
              rsp_valid <= 1'b1;
              rsp_data  <= stat_word;
            end
            default: ;
          endcase
        end
        ST_ACC1: state_q <= ST_ACC2;
        ST_ACC2: begin
          state_q <= ST_IDLE;
          if (!drop_q) begin
            if (op_q == OP_PUSH) begin
              wr_r[qid_q]  <= ptr_next(wr_r[qid_q], szc_r[qid_q]);
              cnt_r[qid_q] <= cnt_r[qid_q] + 1'b1;
            end else begin
              rd_r[qid_q]  <= ptr_next(rd_r[qid_q], szc_r[qid_q]);
              cnt_r[qid_q] <= cnt_r[qid_q] - 1'b1;
            end
          end
          if (op_q == OP_POP) begin
            rsp_valid <= 1'b1;
            rsp_data  <= drop_q ? '0 : ram_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // sticky error bits, low queues only
  always_ff @(posedge clk) begin
    if (rst) begin
      unf_r <= '0;
      ovf_r <= '0;
    end else begin
      for (int q = 0; q < LOW_Q; q++) begin
        if (state_q == ST_ACC2 && drop_q && qid_q == QID_W'(q)) begin
          if (op_q == OP_POP) unf_r[q] <= 1'b1;
          else                ovf_r[q] <= 1'b1;
        end else if (accept && req_op_e == OP_CLR && req_qid == QID_W'(q)) begin
          if (req_wdata[0]) unf_r[q] <= 1'b0;
          if (req_wdata[1]) ovf_r[q] <= 1'b0;
        end
      end
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_flag
    sqm_flag_eval #(.CNT_W(CNT_W), .MIN_WORDS(MIN_WORDS)) u_eval (
      .clk       (clk),
      .rst       (rst),
      .cnt       (cnt_r[q]),
      .size_code (szc_r[q]),
      .ne_wm     (ne_r[q]),
      .nf_wm     (nf_r[q]),
      .flags     (flg[q])
    );
  end

  for (genvar q = 0; q < LOW_Q; q++) begin : g_bus
    assign flag_bus[4*q +: 4] = flg[q];

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ACC2 && op_q == OP_PUSH && drop_q && qid_q == QID_W'(q)) |=> ovf_r[q]);
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (unf_r[q] && !(accept && req_op_e == OP_CLR && req_qid == QID_W'(q) && req_wdata[0])) |=> unf_r[q]);
  end

  // R11
  acc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACC1) |=> (state_q == ST_ACC2));
  // R11
  pop_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACC2 && op_q == OP_POP) |=> rsp_valid);
  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACC2 && drop_q) |=> (cnt_r[qid_q] == $past(cnt_r[qid_q])));
endmodule

// File: tb/shared_queue_mgr_tb_top.sv
module shared_queue_mgr_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [2:0]   req_op = '0;
  logic [5:0]   req_qid = '0;
  logic [31:0]  req_wdata = '0;
  logic         busy;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic [127:0] flag_bus;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model
  logic [31:0] mram [2048];
  int m_base[64], m_cap[64], m_ne[64], m_nf[64], m_rd[64], m_wr[64], m_cnt[64];
  bit m_unf[64], m_ovf[64];

  // scoreboard
  logic [31:0] exp_d[$];
  string       exp_tag[$];

  always #5 clk = ~clk;

  shared_queue_mgr dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_qid(req_qid), .req_wdata(req_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .flag_bus(flag_bus)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_flags(input int q);
    logic [3:0] f;
    f[0] = (m_cnt[q] == 0);
    f[1] = (m_cnt[q] <= m_ne[q]);
    f[2] = ((m_cap[q] - m_cnt[q]) <= m_nf[q]);
    f[3] = (m_cnt[q] == m_cap[q]);
    return f;
  endfunction

  function automatic logic [31:0] exp_stat(input int q);
    logic [31:0] w = '0;
    w[31:24] = 8'(m_cnt[q]);
    w[22:16] = 7'(m_rd[q]);
    w[14:8]  = 7'(m_wr[q]);
    w[5]     = m_ovf[q];
    w[4]     = m_unf[q];
    w[3:0]   = exp_flags(q);
    return w;
  endfunction

  // monitor: compares every response against the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_d.size() == 0) chk(1'b0, "R11 unexpected rsp_valid", rsp_data, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_d.pop_front();
        t = exp_tag.pop_front();
        chk(rsp_data === e, t, rsp_data, e);
      end
    end
  end

  task automatic drive(input logic [2:0] op, input int q, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_qid = 6'(q); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_stat(input int q, input string tag);
    exp_d.push_back(exp_stat(q));
    exp_tag.push_back(tag);
    drive(3'd3, q, 32'h0);
  endtask

  task automatic check_flags(input int q, input string tag);
    if (q < 32) chk(flag_bus[4*q +: 4] === exp_flags(q), tag,
                    32'(flag_bus[4*q +: 4]), 32'(exp_flags(q)));
    else do_stat(q, tag);
  endtask

  task automatic check_bus_all(input string tag);
    for (int q = 0; q < 32; q++) check_flags(q, tag);
  endtask

  task automatic do_cfg(input int q, input int base, input int code, input int ne, input int nf);
    m_base[q] = base; m_cap[q] = 16 << code; m_ne[q] = ne; m_nf[q] = nf;
    m_rd[q] = 0; m_wr[q] = 0; m_cnt[q] = 0;
    drive(3'd2, q, {8'(nf), 8'(ne), 2'b00, 2'(code), 1'b0, 11'(base)});
    @(negedge clk);
    check_flags(q, "R3 flags after configure");
  endtask

  task automatic do_push(input int q, input logic [31:0] d);
    if (m_cnt[q] == m_cap[q]) begin
      if (q < 32) m_ovf[q] = 1'b1;
    end else begin
      mram[(m_base[q] + m_wr[q]) % 2048] = d;
      m_wr[q] = (m_wr[q] + 1) % m_cap[q];
      m_cnt[q]++;
    end
    drive(3'd0, q, d);
    repeat (3) @(negedge clk);
    check_flags(q, "R5 R6 flags after push");
  endtask

  task automatic do_pop(input int q);
    if (m_cnt[q] == 0) begin
      exp_d.push_back(32'h0); exp_tag.push_back("R7 pop of empty returns 0");
      if (q < 32) m_unf[q] = 1'b1;
    end else begin
      exp_d.push_back(mram[(m_base[q] + m_rd[q]) % 2048]);
      exp_tag.push_back("R2 R4 pop order");
      m_rd[q] = (m_rd[q] + 1) % m_cap[q];
      m_cnt[q]--;
    end
    drive(3'd1, q, 32'h0);
    repeat (3) @(negedge clk);
    check_flags(q, "R5 R6 flags after pop");
  endtask

  task automatic do_clr(input int q, input logic [1:0] bits);
    if (q < 32) begin
      if (bits[0]) m_unf[q] = 1'b0;
      if (bits[1]) m_ovf[q] = 1'b0;
    end
    drive(3'd4, q, {30'h0, bits});
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    for (int q = 0; q < 64; q++) begin
      m_base[q] = 0; m_cap[q] = 16; m_ne[q] = 0; m_nf[q] = 0;
      m_rd[q] = 0; m_wr[q] = 0; m_cnt[q] = 0; m_unf[q] = 0; m_ovf[q] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0, "R1 busy after reset", 32'(busy), 32'h0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    check_bus_all("R1 R10 flag bus after reset");
    do_stat(5, "R1 status after reset");
    do_stat(50, "R1 R12 high queue status after reset");

    // R3 configuration
    do_cfg(0, 0, 0, 2, 3);
    do_cfg(1, 16, 1, 4, 4);
    do_cfg(2, 64, 2, 1, 1);
    do_cfg(40, 256, 3, 10, 10);
    do_cfg(41, 512, 0, 0, 0);

    // R2 interleaved traffic across queues
    do_push(0, 32'hA000_0000);
    do_push(1, 32'hB000_0000);
    do_push(0, 32'hA000_0001);
    do_push(40, 32'hC000_0000);
    do_push(1, 32'hB000_0001);
    do_push(0, 32'hA000_0002);
    do_pop(1);
    do_pop(0);
    do_pop(40);
    do_pop(0);
    do_pop(1);
    do_pop(0);
    do_stat(0, "R12 status after traffic");
    check_bus_all("R10 flag bus after traffic");

    // R5 R7 fill queue 0 to capacity starting at pointer 3, overflow
    for (int i = 0; i < 16; i++) do_push(0, 32'hA100_0000 + 32'(i));
    do_stat(0, "R5 full status");
    do_push(0, 32'hDEAD_BEEF);
    do_stat(0, "R7 overflow after drop");
    do_push(1, 32'hB100_0000);
    do_pop(1);
    do_stat(0, "R8 overflow held");
    for (int i = 0; i < 17; i++) do_pop(0);
    do_stat(0, "R7 underflow after empty pop");

    // R8 write-one-to-clear
    do_clr(0, 2'b10);
    do_stat(0, "R8 clear overflow only");
    do_clr(0, 2'b00);
    do_stat(0, "R8 zero mask keeps underflow");
    do_clr(0, 2'b01);
    do_stat(0, "R8 clear underflow");

    // R4 wrap runs on a 64-word queue with two words in flight
    do_push(2, 32'hE000_0000);
    do_push(2, 32'hE000_0001);
    for (int i = 0; i < 150; i++) begin
      do_push(2, 32'hE100_0000 + 32'(i));
      do_pop(2);
    end
    do_stat(2, "R4 pointers after wraps");

    // R9 high queue has no sticky bits
    for (int i = 0; i < 16; i++) do_push(41, 32'hF000_0000 + 32'(i));
    do_push(41, 32'hF0FF_FFFF);
    for (int i = 0; i < 17; i++) do_pop(41);
    do_stat(41, "R9 no sticky on high queue");

    // R3 reconfigure a non-empty queue
    do_push(1, 32'hB200_0000);
    do_push(1, 32'hB200_0001);
    do_push(1, 32'hB200_0002);
    do_cfg(1, 600, 0, 0, 0);
    do_stat(1, "R3 reconfigure resets state");
    do_push(1, 32'hB300_0000);
    do_pop(1);

    // R11 cycle timing of a pop
    do_push(0, 32'h1234_5678);
    exp_d.push_back(mram[(m_base[0] + m_rd[0]) % 2048]);
    exp_tag.push_back("R11 pop data");
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_qid = 6'd0; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R11 busy first cycle", 32'(busy), 32'h1);
    @(negedge clk);
    chk(busy === 1'b1, "R11 busy second cycle", 32'(busy), 32'h1);
    chk(rsp_valid === 1'b0, "R11 no early rsp", 32'(rsp_valid), 32'h0);
    @(negedge clk);
    chk(busy === 1'b0, "R11 busy released", 32'(busy), 32'h0);
    chk(rsp_valid === 1'b1, "R11 rsp_valid after access", 32'(rsp_valid), 32'h1);
    chk(flag_bus[3:0] === 4'b0010, "R11 flags not yet updated", 32'(flag_bus[3:0]), 32'h2);
    m_rd[0] = (m_rd[0] + 1) % m_cap[0];
    m_cnt[0]--;
    @(negedge clk);
    chk(flag_bus[3:0] === 4'b0011, "R11 flags one cycle later", 32'(flag_bus[3:0]), 32'h3);
    check_bus_all("R10 final flag bus");
    chk(exp_d.size() == 0, "R2 scoreboard drained", 32'(exp_d.size()), 32'h0);

    done = 1;
    finish_run();
  end
endmodule